// File: doc/BRIEF.md
# Packet batching receive buffer manager

This block gathers variable-length packets from a valid/ready word stream into a local word-addressed RAM, so that a host can move many packets in one transfer instead of paying the per-packet cost each time. Every packet is stored on a 32-bit word boundary. It is stored as one header word that holds its byte length, followed by its payload words, and the next packet starts directly after it. The block keeps a packet count and the next free word address.

A batch opens on a start command and closes in one of two ways. It closes when the space left can no longer hold a packet of the largest size. It also closes when an idle timer, started with the batch, has expired while at least one packet is stored and no packet is partly received. While the batch is closed, the block shows the packet count and the end address on its control port and holds them until the next start. A read port gives the host access to the stored words. The usable buffer size and the timer limit are set for each batch at start.

Top module: `pkt_batch_rx`

## Requirements
- R1: After reset the block is closed: `done` is 1, `batch_count` and `batch_end` are 0, and `s_ready` is 0.
- R2: A `start` pulse while `done` is 1 opens a batch. In the next cycle `done` is 0, `s_ready` is 1, and the count and end address are 0. A `start` while a batch is open has no effect on the stored packets or on the count.
- R3: Each packet occupies words base..base+W, where W is its beat count. Word base holds the byte length in bits 15:0 with zeros above. The payload beats follow at base+1 onward, in arrival order.
- R4: On the last beat, `s_lbytes` gives the valid bytes of that beat: code 0 means 4 bytes and codes 1..3 mean that many. The stored length is 4*(W-1) plus that value.
- R5: Each stored packet adds exactly one to the count and moves the end address from base to base+1+W.
- R6: After a packet is stored, the batch closes in the following cycle if (limit - end) < ceil(MAX_BYTES/4)+1. Otherwise it stays open.
- R7: The limit is sampled from `cfg_limit` at start and clamped to the range [ceil(MAX_BYTES/4)+1, 2^DEPTH_W].
- R8: The timer counts clock edges from the start edge. With T = `cfg_timeout` sampled at start, at least one packet stored and none in progress, `done` rises at the (T+1)th edge after the start edge.
- R9: A timeout with no packet stored does not close the batch and `s_ready` stays 1. The first packet after that is stored, and the batch closes right after it.
- R10: A packet that is in progress when the timer expires is taken in full, stored, and counted before the batch closes.
- R11: `s_ready` is 0 while `done` is 1, and in the cycle that follows an accepted last beat.
- R12: While closed, `batch_count` and `batch_end` hold their values, whatever the stream inputs do.
- R13: `rd_data` returns the word at `rd_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Block accepts a beat |
| s_data | input | 32 | Stream beat data |
| s_last | input | 1 | Final beat of a packet |
| s_lbytes | input | 2 | Valid bytes on the final beat (0 means 4) |
| start | input | 1 | Open a new batch (acted on only while closed) |
| cfg_limit | input | DEPTH_W+1 | Usable buffer size in words, sampled at start |
| cfg_timeout | input | TMO_W | Timer limit in cycles, sampled at start |
| done | output | 1 | Batch closed, report valid |
| batch_count | output | DEPTH_W+1 | Packets stored in the batch |
| batch_end | output | DEPTH_W+1 | First free word address, upper bound of valid data |
| rd_addr | input | DEPTH_W | Host read address |
| rd_data | output | 32 | Host read data, one cycle latency |

## Verification
The bench builds the block with a 512-word buffer (DEPTH_W=9), a 256-byte largest packet (65 reserved words) and a 16-bit timer. With these sizes a random limit between 65 and 512 words fills in a handful of packets of up to 64 beats. Both clamp edges are easy to reach: a limit below 65 and a limit above 512. Timer values of 10 to 2000 cycles let the bench check the exact closing edge, a timer that expires with nothing stored, and a timer that expires in the middle of a gapped long packet.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_INC  = 2'd1,
    ST_DONE = 2'd2
  } pbr_state_e;

  // valid bytes carried by a final beat; code zero stands for a full word
  function automatic logic [15:0] last_bytes(input logic [1:0] code);
    last_bytes = (code == 2'd0) ? 16'd4 : {14'd0, code};
  endfunction

  function automatic logic [31:0] hdr_word(input logic [15:0] nbytes);
    hdr_word = {16'd0, nbytes};
  endfunction

endpackage

// File: rtl/pbr_rst_sync.sv
module pbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/pbr_ram.sv
module pbr_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbr_timer.sv
module pbr_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [TW-1:0] lim_in,
  output logic          fired
);
  logic [TW-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic          upd;

  assign fired = (cnt_q == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    upd   = 1'b0;
    if (load) begin
      cnt_d = '0;
      lim_d = lim_in;
      upd   = 1'b1;
    end else if (run && !fired) begin
      cnt_d = cnt_q + TW'(1);
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/pbr_rx.sv
module pbr_rx import pbr_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          s_valid,
  input  logic [31:0]   s_data,
  input  logic          s_last,
  input  logic [1:0]    s_lbytes,
  input  logic [AW:0]   base,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          busy,
  output logic [AW:0]   pkt_words,
  output logic [15:0]   pkt_bytes
);
  logic [AW:0] beat_q, beat_d, words_q, words_d;
  logic [15:0] bytes_q, bytes_d;
  logic        fire, upd;

  assign fire      = en & s_valid;
  assign wr_en     = fire;
  assign wr_addr   = AW'(base + beat_q + (AW+1)'(1));
  assign wr_data   = s_data;
  assign busy      = (beat_q != '0);
  assign pkt_words = words_q;
  assign pkt_bytes = bytes_q;

  always_comb begin
    beat_d  = beat_q;
    words_d = words_q;
    bytes_d = bytes_q;
    upd     = clr | fire;
    if (clr) begin
      beat_d = '0;
    end else if (fire) begin
      if (s_last) begin
        beat_d  = '0;
        words_d = beat_q + (AW+1)'(1);
        bytes_d = (16'(beat_q) << 2) + last_bytes(s_lbytes);
      end else begin
        beat_d = beat_q + (AW+1)'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      words_q <= '0;
      bytes_q <= '0;
    end else if (upd) begin
      beat_q  <= beat_d;
      words_q <= words_d;
      bytes_q <= bytes_d;
    end
  end
endmodule

// File: rtl/pkt_batch_rx.sv
module pkt_batch_rx import pbr_pkg::*; #(
  parameter int DEPTH_W   = 10,
  parameter int MAX_BYTES = 1518,
  parameter int TMO_W     = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [31:0]        s_data,
  input  logic               s_last,
  input  logic [1:0]         s_lbytes,
  input  logic               start,
  input  logic [DEPTH_W:0]   cfg_limit,
  input  logic [TMO_W-1:0]   cfg_timeout,
  output logic               done,
  output logic [DEPTH_W:0]   batch_count,
  output logic [DEPTH_W:0]   batch_end,
  input  logic [DEPTH_W-1:0] rd_addr,
  output logic [31:0]        rd_data
);
  localparam int PW        = DEPTH_W + 1;
  localparam int DEPTH     = 1 << DEPTH_W;
  localparam int MAX_WORDS = (MAX_BYTES + WORD_BYTES - 1) / WORD_BYTES;
  localparam int RESERVE   = MAX_WORDS + 1;
  localparam logic [PW-1:0] RESERVE_V = PW'(RESERVE);
  localparam logic [PW-1:0] DEPTH_V   = PW'(DEPTH);

  logic          rst_n_s;
  pbr_state_e    st_q, st_d;
  logic [PW-1:0] base_q, base_d, cnt_q, cnt_d, lim_q, lim_clamped;
  logic [PW-1:0] next_base, room, pkt_words;
  logic [15:0]   pkt_bytes;
  logic          go, ctr_en, idle_close, fire_last, rx_busy, tmo_fired;
  logic          rx_we, ram_we;
  logic [DEPTH_W-1:0] rx_waddr, ram_waddr;
  logic [31:0]   rx_wdata, ram_wdata;

  pbr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  pbr_rx #(.AW(DEPTH_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .clr(st_q != ST_WAIT), .en(s_ready),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_lbytes(s_lbytes),
    .base(base_q), .wr_en(rx_we), .wr_addr(rx_waddr), .wr_data(rx_wdata),
    .busy(rx_busy), .pkt_words(pkt_words), .pkt_bytes(pkt_bytes)
  );

  pbr_timer #(.TW(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(go), .run(st_q != ST_DONE),
    .lim_in(cfg_timeout), .fired(tmo_fired)
  );

  pbr_ram #(.AW(DEPTH_W), .DW(32)) u_ram (
    .clk(clk), .rst_n(rst_n_s), .we(ram_we), .waddr(ram_waddr),
    .wdata(ram_wdata), .raddr(rd_addr), .rdata(rd_data)
  );

  // control decode
  assign go         = start & (st_q == ST_DONE);
  assign idle_close = ~rx_busy & tmo_fired & (cnt_q != '0);
  assign s_ready    = (st_q == ST_WAIT) & ~idle_close;
  assign fire_last  = s_ready & s_valid & s_last;
  assign next_base  = base_q + pkt_words + PW'(1);
  assign room       = lim_q - next_base;

  always_comb begin
    if (cfg_limit < RESERVE_V)    lim_clamped = RESERVE_V;
    else if (cfg_limit > DEPTH_V) lim_clamped = DEPTH_V;
    else                          lim_clamped = cfg_limit;
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT: begin
        if (idle_close)     st_d = ST_DONE;
        else if (fire_last) st_d = ST_INC;
      end
      ST_INC: begin
        if ((room < RESERVE_V) || tmo_fired) st_d = ST_DONE;
        else                                  st_d = ST_WAIT;
      end
      ST_DONE: begin
        if (go) st_d = ST_WAIT;
      end
      default: st_d = ST_DONE;
    endcase
  end

  // count and base
  always_comb begin
    ctr_en = go | (st_q == ST_INC);
    base_d = go ? '0 : next_base;
    cnt_d  = go ? '0 : cnt_q + PW'(1);
  end

  // single write port: payload beats while waiting, header on the step
  always_comb begin
    if (st_q == ST_INC) begin
      ram_we    = 1'b1;
      ram_waddr = base_q[DEPTH_W-1:0];
      ram_wdata = hdr_word(pkt_bytes);
    end else begin
      ram_we    = rx_we;
      ram_waddr = rx_waddr;
      ram_wdata = rx_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_DONE;
      base_q <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      st_q <= st_d;
      if (ctr_en) begin
        base_q <= base_d;
        cnt_q  <= cnt_d;
      end
      if (go) lim_q <= lim_clamped;
    end
  end

  assign done        = (st_q == ST_DONE);
  assign batch_count = cnt_q;
  assign batch_end   = base_q;
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int DEPTH_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_last,
  input logic             start,
  input logic             done,
  input logic [DEPTH_W:0] batch_count,
  input logic [DEPTH_W:0] batch_end
);
  localparam int PW    = DEPTH_W + 1;
  localparam int DEPTH = 1 << DEPTH_W;

  a_r11_ready_low_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);

  a_r11_ready_low_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> !s_ready);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> (!done && batch_count == '0 && batch_end == '0));

  a_r12_report_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(batch_count) && $stable(batch_end)));

  a_r9_never_empty_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (batch_count != '0));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (batch_count == $past(batch_count) ||
               batch_count == $past(batch_count) + PW'(1)));

  a_r6_end_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (batch_end <= PW'(DEPTH)));
endmodule

bind pkt_batch_rx pbr_checker #(.DEPTH_W(DEPTH_W)) u_pbr_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .start(start), .done(done),
  .batch_count(batch_count), .batch_end(batch_end)
);

// File: tb/pkt_batch_rx_test.sv
module pkt_batch_rx_test;
  localparam int DW    = 9;
  localparam int DEPTH = 512;
  localparam int MAXB  = 256;
  localparam int RES   = 65;
  localparam int TW    = 16;
  localparam int PW    = DW + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          s_valid, s_ready, s_last, start, done;
  logic [31:0]   s_data, rd_data;
  logic [1:0]    s_lbytes;
  logic [PW-1:0] cfg_limit, batch_count, batch_end;
  logic [TW-1:0] cfg_timeout;
  logic [DW-1:0] rd_addr;

  pkt_batch_rx #(.DEPTH_W(DW), .MAX_BYTES(MAXB), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .s_lbytes(s_lbytes), .start(start),
    .cfg_limit(cfg_limit), .cfg_timeout(cfg_timeout), .done(done),
    .batch_count(batch_count), .batch_end(batch_end),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, start_cyc = 0, m_base = 0, m_cnt = 0, m_lim = 0, tag = 1;
  bit finished = 0;
  logic [31:0] exp_mem [DEPTH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  function automatic logic [31:0] gen(input int t, input int i);
    return (t * 32'h01000193) ^ (i * 32'h9E3779B9) ^ 32'h5A5A0000;
  endfunction

  function automatic int clampl(input int l);
    if (l < RES) return RES;
    if (l > DEPTH) return DEPTH;
    return l;
  endfunction

  task automatic do_start(input int lim, input int tmo);
    @(negedge clk);
    cfg_limit = PW'(lim); cfg_timeout = TW'(tmo); start = 1'b1;
    @(negedge clk);
    start = 1'b0; start_cyc = cyc;
    m_base = 0; m_cnt = 0; m_lim = clampl(lim);
  endtask

  // enters and leaves at a falling edge; leaves in the cycle after the last beat
  task automatic send_pkt(input int nb, input int gap);
    int words = (nb + 3) / 4;
    exp_mem[m_base] = {16'd0, 16'(nb)};
    for (int i = 0; i < words; i++) begin
      int idle = (gap > 0) ? $urandom_range(gap, 0) : 0;
      exp_mem[m_base + 1 + i] = gen(tag, i);
      repeat (idle) begin s_valid = 1'b0; @(negedge clk); end
      s_valid = 1'b1; s_data = gen(tag, i);
      s_last = (i == words - 1); s_lbytes = 2'(nb % 4);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    m_base += 1 + words; m_cnt++; tag++;
  endtask

  task automatic read_word(input int a, output logic [31:0] w);
    rd_addr = a[DW-1:0];
    @(negedge clk);
    w = rd_data;
  endtask

  task automatic check_batch(input string req);
    int first_bad = -1;
    logic [31:0] w, e;
    check(done == 1'b1, req, int'(done), 1);
    check(int'(batch_count) == m_cnt, req, int'(batch_count), m_cnt);
    check(int'(batch_end) == m_base, req, int'(batch_end), m_base);
    e = 0;
    for (int a = 0; a < m_base; a++) begin
      read_word(a, w);
      if (w !== exp_mem[a] && first_bad < 0) begin first_bad = a; e = exp_mem[a]; end
    end
    check(first_bad < 0, {req, " content"}, first_bad, int'(e));
  endtask

  task automatic wait_done(input int maxc);
    int k = 0;
    while (!done && k < maxc) begin @(negedge clk); k++; end
  endtask

  initial begin
    int lim;
    bit closed;
    logic [PW-1:0] c0, e0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; s_valid = 0; s_data = 0; s_last = 0; s_lbytes = 0;
    start = 0; cfg_limit = 0; cfg_timeout = 0; rd_addr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(done == 1'b1 && s_ready == 1'b0, "R1 done/ready", int'({done, s_ready}), 2);
    check(batch_count == 0 && batch_end == 0, "R1 count/end", int'(batch_end), 0);

    // R2, R3, R4, R8: directed sizes for every final-beat code, closed by timer
    do_start(512, 2000);
    check(done == 1'b0 && s_ready == 1'b1, "R2 open", int'({done, s_ready}), 1);
    check(batch_count == 0 && batch_end == 0, "R2 cleared", int'(batch_end), 0);
    send_pkt(1, 0);
    check(s_ready == 1'b0, "R11 ready low after last", int'(s_ready), 0);
    @(negedge clk);
    send_pkt(2, 0); @(negedge clk);
    send_pkt(3, 0); @(negedge clk);
    send_pkt(4, 0); @(negedge clk);
    send_pkt(5, 1); @(negedge clk);
    send_pkt(MAXB, 0);
    wait_done(3000);
    check(cyc - start_cyc == 2001, "R8 close edge", cyc - start_cyc, 2001);
    check_batch("R3 R4 R5");

    // R8 short timer, one packet
    do_start(512, 100);
    send_pkt(8, 0);
    wait_done(500);
    check(cyc - start_cyc == 101, "R8 short timer", cyc - start_cyc, 101);
    check_batch("R8");

    // R9 timer expires with nothing stored
    do_start(512, 10);
    repeat (40) @(negedge clk);
    check(done == 1'b0 && s_ready == 1'b1, "R9 stays open", int'({done, s_ready}), 1);
    send_pkt(12, 0);
    @(negedge clk);
    check(done == 1'b1, "R9 close after first", int'(done), 1);
    check_batch("R9");

    // R10 timer expires mid-packet
    do_start(512, 20);
    send_pkt(4, 0); @(negedge clk);
    send_pkt(200, 3);
    @(negedge clk);
    check(done == 1'b1, "R10 close after packet", int'(done), 1);
    check_batch("R10");

    // R7 low clamp with a full-size packet, R6 exact fit
    do_start(5, 16'hFFFF);
    send_pkt(MAXB, 0);
    @(negedge clk);
    check(done == 1'b1, "R7 low clamp", int'(done), 1);
    check_batch("R7");

    // R2 start ignored while open
    do_start(RES + 4, 16'hFFFF);
    send_pkt(8, 0);
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(int'(batch_count) == 1, "R2 start ignored", int'(batch_count), 1);
    send_pkt(4, 0);
    @(negedge clk);
    check_batch("R2 R6");

    // R12 stream activity while closed
    c0 = batch_count; e0 = batch_end;
    s_valid = 1'b1; s_last = 1'b1; s_data = 32'hDEAD_BEEF;
    repeat (6) @(negedge clk);
    check(s_ready == 1'b0, "R12 ready low", int'(s_ready), 0);
    check(batch_count == c0 && batch_end == e0, "R12 hold", int'(batch_end), int'(e0));
    s_valid = 1'b0; s_last = 1'b0;

    // R7 high clamp, then random batches (R6, R13)
    for (int b = 0; b < 7; b++) begin
      lim = (b == 0) ? 1023 : RES + $urandom_range(DEPTH - RES, 0);
      do_start(lim, 16'hFFFF);
      closed = 0;
      while (!closed) begin
        send_pkt($urandom_range(MAXB, 1), $urandom_range(2, 0));
        closed = (m_lim - m_base) < RES;
        @(negedge clk);
        check(done == closed, "R6 fit close", int'(done), int'(closed));
        if (done != closed) closed = 1;
      end
      wait_done(10);
      check_batch((b == 0) ? "R7 high clamp" : "R6 R13 random");
    end

    report();
  end
endmodule